// File: doc/BRIEF.md
# Variable-Length Seed Scan Decompressor

This block turns short serial seeds into full scan-chain patterns. A Galois-style linear feedback shift register of `LFSR_W` stages receives a seed over a one-bit serial port. The register is then clocked for `CHAIN_LEN` cycles, and its top stage is driven onto the scan-chain serial output while scan enable is high. A new seed is loaded for every pattern. Seeds need not fill the whole register. The controller keeps a current seed length. It starts at a base length and grows by a fixed step whenever the leading flag bit of a seed frame asks for it, up to the register width.

A mode input selects between two behaviours. In deterministic mode each pattern consumes one seed frame: a flag bit first, then exactly the current number of seed bits. In free-running mode the register drives patterns back to back with no seed at all, and the serial input is ignored.

The controller has three states. `ST_IDLE` waits between patterns. `ST_LOAD` writes seed bits. `ST_FILL` clocks the chain. The transitions are:
- IDLE→LOAD when a flag bit is accepted in deterministic mode; the register is cleared on this transition.
- IDLE→FILL in free-running mode.
- LOAD→LOAD while seed bits remain.
- LOAD→FILL on the last seed bit.
- FILL→FILL while the chain is filling.
- FILL→IDLE on the last fill cycle.

Top module: `lfsr_decompressor`

## Requirements
- R1: After reset, scan_en and pattern_done are low and the current seed length equals BASE_LEN.
- R2: In deterministic mode the first accepted serial bit of a frame is the grow flag. A 1 raises the current length by LEN_STEP, and the new length already applies to the seed bits that follow in the same frame. A 0 keeps the length.
- R3: The current length never exceeds LFSR_W. A grow flag at length LFSR_W leaves it at LFSR_W.
- R4: Loading clears every stage, then writes seed bit j (sent in order j = 0, 1, ...) into stage j. Stages at or above the current length stay 0.
- R5: The cycle after the last seed bit is accepted, scan_en is high for exactly CHAIN_LEN consecutive cycles. In each of those cycles scan_out equals stage LFSR_W-1 before the register steps. A step shifts toward higher stages and, when stage LFSR_W-1 is 1, XORs the shifted value with POLY (bit 0 included).
- R6: pattern_done is a single-cycle pulse on the last fill cycle of each pattern and is low otherwise.
- R7: In free-running mode patterns follow one another with one idle cycle between them. The register continues from where the previous pattern left it, and seed_valid/seed_bit have no effect on the output.
- R8: Entering a free-running pattern with an all-zero register first presets it to RAND_INIT.
- R9: While seed_valid is low during loading, no bit is consumed and the fill does not start. Serial input during a fill changes neither the stream nor the pattern length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_det | input | 1 | 1 = deterministic seeds, 0 = free-running; sampled in idle |
| seed_bit | input | 1 | Serial grow flag / seed data |
| seed_valid | input | 1 | Qualifies seed_bit |
| scan_out | output | 1 | Scan-chain serial data, low outside fills |
| scan_en | output | 1 | High during the fill of the chain |
| pattern_done | output | 1 | Pulse on the last fill cycle |

## Verification
The bench builds the block with its defaults: a 32-stage register, a 64-bit chain, base length 8 and step 4. With these values, six grow flags walk the length through every value from 8 to 32, and a seventh reaches saturation. The 64-cycle fill is long enough that every seed stage reaches the output. Each stream is compared bit by bit with a software model of the register, seeded with the masked seed. Stalls during loading, serial traffic during fills, a zero seed followed by free-running mode, and a mid-run reset cover the remaining paths.

// File: rtl/lfsr_decomp_pkg.sv
package lfsr_decomp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_FILL
    } dec_state_e;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_CLEAR,
        OP_WRITE,
        OP_STEP,
        OP_PRESET
    } lfsr_op_e;

endpackage

// File: rtl/lfsr_core.sv
module lfsr_core
    import lfsr_decomp_pkg::*;
#(
    parameter int          LFSR_W    = 32,
    parameter logic [LFSR_W-1:0] POLY      = 32'h0040_0007,
    parameter logic [LFSR_W-1:0] RAND_INIT = 32'h1ACE_5EED,
    localparam int         IDX_W     = $clog2(LFSR_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lfsr_op_e          op,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_bit,
    output logic [LFSR_W-1:0] state_q
);

    logic [LFSR_W-1:0] step_v;
    logic [LFSR_W-1:0] next_v;
    logic              top_bit;

    assign top_bit = state_q[LFSR_W-1];

    // Internal-XOR step: each stage takes its lower neighbour, tapped stages add the top bit
    generate
        for (genvar g = 0; g < LFSR_W; g++) begin : g_stage
            if (g == 0) begin : g_lsb
                assign step_v[g] = top_bit & POLY[g];
            end else begin : g_mid
                assign step_v[g] = state_q[g-1] ^ (top_bit & POLY[g]);
            end
        end
    endgenerate

    always_comb begin
        next_v = state_q;
        unique case (op)
            OP_HOLD:   next_v = state_q;
            OP_CLEAR:  next_v = '0;
            OP_WRITE:  next_v[wr_idx] = wr_bit;
            OP_STEP:   next_v = step_v;
            OP_PRESET: next_v = RAND_INIT;
            default:   next_v = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RAND_INIT;
        end else begin
            state_q <= next_v;
        end
    end

endmodule

// File: rtl/decomp_ctrl.sv
module decomp_ctrl
    import lfsr_decomp_pkg::*;
#(
    parameter int  LFSR_W    = 32,
    parameter int  CHAIN_LEN = 64,
    parameter int  BASE_LEN  = 8,
    parameter int  LEN_STEP  = 4,
    localparam int IDX_W     = $clog2(LFSR_W),
    localparam int LEN_W     = $clog2(LFSR_W + 1),
    localparam int FILL_W    = $clog2(CHAIN_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_det,
    input  logic             seed_bit,
    input  logic             seed_valid,
    input  logic             lfsr_zero,
    output lfsr_op_e         op,
    output logic [IDX_W-1:0] wr_idx,
    output logic             scan_en,
    output logic             pattern_done,
    output logic [LEN_W-1:0] cur_len
);

    dec_state_e        state_q, state_d;
    logic [IDX_W-1:0]  bit_q;
    logic [FILL_W-1:0] fill_q;
    logic [LEN_W-1:0]  len_q;
    logic              load_last;
    logic              fill_last;
    logic              frame_start;

    function automatic logic [LEN_W-1:0] grow(input logic [LEN_W-1:0] l);
        logic [LEN_W:0] s;
        s = {1'b0, l} + (LEN_W+1)'(LEN_STEP);
        return (s > (LEN_W+1)'(LFSR_W)) ? LEN_W'(LFSR_W) : s[LEN_W-1:0];
    endfunction

    assign frame_start = (state_q == ST_IDLE) && mode_det && seed_valid;
    assign load_last   = seed_valid && (LEN_W'(bit_q) == len_q - LEN_W'(1));
    assign fill_last   = (fill_q == FILL_W'(CHAIN_LEN - 1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!mode_det)        state_d = ST_FILL;
                else if (seed_valid)  state_d = ST_LOAD;
            end
            ST_LOAD: if (load_last) state_d = ST_FILL;
            ST_FILL: if (fill_last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Counters and seed length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q  <= '0;
            fill_q <= '0;
            len_q  <= LEN_W'(BASE_LEN);
        end else begin
            if (frame_start) begin
                bit_q <= '0;
                if (seed_bit) len_q <= grow(len_q);
            end else if (state_q == ST_LOAD && seed_valid) begin
                bit_q <= bit_q + IDX_W'(1);
            end
            if (state_q == ST_FILL) fill_q <= fill_last ? '0 : fill_q + FILL_W'(1);
            else                    fill_q <= '0;
        end
    end

    // Outputs
    always_comb begin
        op           = OP_HOLD;
        wr_idx       = bit_q;
        scan_en      = 1'b0;
        pattern_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!mode_det)       op = lfsr_zero ? OP_PRESET : OP_HOLD;
                else if (seed_valid) op = OP_CLEAR;
            end
            ST_LOAD: op = seed_valid ? OP_WRITE : OP_HOLD;
            ST_FILL: begin
                op           = OP_STEP;
                scan_en      = 1'b1;
                pattern_done = fill_last;
            end
            default: op = OP_HOLD;
        endcase
    end

    assign cur_len = len_q;

endmodule

// File: rtl/lfsr_decompressor.sv
module lfsr_decompressor
    import lfsr_decomp_pkg::*;
#(
    parameter int                LFSR_W    = 32,
    parameter int                CHAIN_LEN = 64,
    parameter int                BASE_LEN  = 8,
    parameter int                LEN_STEP  = 4,
    parameter logic [LFSR_W-1:0] POLY      = 32'h0040_0007,
    parameter logic [LFSR_W-1:0] RAND_INIT = 32'h1ACE_5EED,
    localparam int               IDX_W     = $clog2(LFSR_W),
    localparam int               LEN_W     = $clog2(LFSR_W + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_det,
    input  logic seed_bit,
    input  logic seed_valid,
    output logic scan_out,
    output logic scan_en,
    output logic pattern_done
);

    lfsr_op_e          op;
    logic [IDX_W-1:0]  wr_idx;
    logic [LFSR_W-1:0] lfsr_q;
    logic [LEN_W-1:0]  cur_len;
    logic              fill_en;

    decomp_ctrl #(
        .LFSR_W    (LFSR_W),
        .CHAIN_LEN (CHAIN_LEN),
        .BASE_LEN  (BASE_LEN),
        .LEN_STEP  (LEN_STEP)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_det     (mode_det),
        .seed_bit     (seed_bit),
        .seed_valid   (seed_valid),
        .lfsr_zero    (lfsr_q == '0),
        .op           (op),
        .wr_idx       (wr_idx),
        .scan_en      (fill_en),
        .pattern_done (pattern_done),
        .cur_len      (cur_len)
    );

    lfsr_core #(
        .LFSR_W    (LFSR_W),
        .POLY      (POLY),
        .RAND_INIT (RAND_INIT)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .wr_idx  (wr_idx),
        .wr_bit  (seed_bit),
        .state_q (lfsr_q)
    );

    assign scan_en  = fill_en;
    assign scan_out = fill_en & lfsr_q[LFSR_W-1];

endmodule

// File: rtl/lfsr_decompressor_chk.sv
module lfsr_decompressor_chk #(
    parameter int  LFSR_W    = 32,
    parameter int  CHAIN_LEN = 64,
    parameter int  BASE_LEN  = 8,
    parameter int  LEN_STEP  = 4,
    localparam int LEN_W     = $clog2(LFSR_W + 1),
    localparam int RUN_W     = $clog2(CHAIN_LEN) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scan_en,
    input logic             scan_out,
    input logic             pattern_done,
    input logic [LEN_W-1:0] cur_len
);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_q <= '0;
        else if (scan_en) run_q <= run_q + RUN_W'(1);
        else              run_q <= '0;
    end

    // R6: the done pulse lies inside a fill and closes it
    a_r6_done_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
        pattern_done |-> scan_en);
    a_r6_done_ends_fill: assert property (@(posedge clk) disable iff (!rst_n)
        pattern_done |=> !scan_en);

    // R5: every fill lasts exactly CHAIN_LEN cycles
    a_r5_fill_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_en) |-> (run_q == RUN_W'(CHAIN_LEN)));

    // R5: scan_out is quiet outside a fill
    a_r5_out_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |-> !scan_out);

    // R3: length stays within its range
    a_r3_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_len <= LEN_W'(LFSR_W)) && (cur_len >= LEN_W'(BASE_LEN)));

    // R2: length only changes by one step or by clamping to the width
    a_r2_len_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_len != $past(cur_len)) |->
            ((cur_len == $past(cur_len) + LEN_W'(LEN_STEP)) || (cur_len == LEN_W'(LFSR_W))));

endmodule

bind lfsr_decompressor lfsr_decompressor_chk #(
    .LFSR_W    (LFSR_W),
    .CHAIN_LEN (CHAIN_LEN),
    .BASE_LEN  (BASE_LEN),
    .LEN_STEP  (LEN_STEP)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scan_en      (scan_en),
    .scan_out     (scan_out),
    .pattern_done (pattern_done),
    .cur_len      (cur_len)
);

// File: tb/lfsr_decompressor_tb.sv
module lfsr_decompressor_tb;

    localparam int          W      = 32;
    localparam int          CHAIN  = 64;
    localparam logic [31:0] POLY   = 32'h0040_0007;
    localparam logic [31:0] RINIT  = 32'h1ACE_5EED;
    localparam int          NVEC   = 10;

    // {expected length[47:40], pad[39:35], junk-in-fill[34], stall[33], grow flag[32], seed[31:0]}
    localparam logic [47:0] VEC [NVEC] = '{
        {8'd8,  5'd0, 1'b0, 1'b0, 1'b0, 32'hDEAD_BEA5},
        {8'd12, 5'd0, 1'b0, 1'b0, 1'b1, 32'h0000_0C3F},
        {8'd12, 5'd0, 1'b0, 1'b1, 1'b0, 32'hFFFF_F801},
        {8'd16, 5'd0, 1'b1, 1'b0, 1'b1, 32'h1234_8001},
        {8'd20, 5'd0, 1'b0, 1'b0, 1'b1, 32'h000A_5A5A},
        {8'd24, 5'd0, 1'b0, 1'b0, 1'b1, 32'h7780_0001},
        {8'd28, 5'd0, 1'b0, 1'b1, 1'b1, 32'hF9AB_CDEF},
        {8'd32, 5'd0, 1'b0, 1'b0, 1'b1, 32'h8000_0000},
        {8'd32, 5'd0, 1'b0, 1'b0, 1'b1, 32'hC001_D00D},
        {8'd32, 5'd0, 1'b1, 1'b0, 1'b0, 32'h0F0F_3C3C}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_det = 1'b1;
    logic seed_bit = 1'b0;
    logic seed_valid = 1'b0;
    logic scan_out, scan_en, pattern_done;

    int checks = 0;
    int errors = 0;
    logic [31:0] rmodel;

    always #5 clk = ~clk;

    lfsr_decompressor u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_det     (mode_det),
        .seed_bit     (seed_bit),
        .seed_valid   (seed_valid),
        .scan_out     (scan_out),
        .scan_en      (scan_en),
        .pattern_done (pattern_done)
    );

    function automatic logic [31:0] mstep(input logic [31:0] s);
        return {s[30:0], 1'b0} ^ (s[31] ? POLY : 32'h0);
    endfunction

    function automatic logic [31:0] lmask(input int len);
        logic [63:0] m;
        m = (64'd1 << len) - 64'd1;
        return m[31:0];
    endfunction

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One fill starting at the current negedge; model holds the expected register.
    task automatic collect(inout logic [31:0] m, input logic junk, input logic next_det, input string req);
        int bad = 0;
        int dbad = 0;
        int enbad = 0;
        for (int i = 0; i < CHAIN; i++) begin
            if (!scan_en) enbad++;
            if (scan_out !== m[31]) bad++;
            if (pattern_done !== (i == CHAIN - 1)) dbad++;
            m = mstep(m);
            if (junk) begin
                seed_valid = 1'b1;
                seed_bit   = ~seed_bit;
            end
            if (i == CHAIN - 1) begin
                seed_valid = 1'b0;
                mode_det   = next_det;
            end
            @(negedge clk);
        end
        check(bad == 0, {req, " stream (R5)"}, bad, 0);
        check(enbad == 0 && !scan_en, {req, " fill length (R5)"}, enbad, 0);
        check(dbad == 0, {req, " done pulse (R6)"}, dbad, 0);
    endtask

    task automatic run_det(input logic flag, input logic stall, input logic junk,
                           input logic [31:0] seed, input int len, input string req);
        logic [31:0] m;
        int early = 0;
        m = seed & lmask(len);
        @(negedge clk);
        seed_valid = 1'b1;
        seed_bit   = flag;
        for (int j = 0; j < len; j++) begin
            @(negedge clk);
            if (scan_en) early++;
            if (stall && j == 2) begin
                seed_valid = 1'b0;
                seed_bit   = 1'b1;
                @(negedge clk);
                if (scan_en) early++;
                seed_valid = 1'b1;
            end
            seed_bit = seed[j];
        end
        @(negedge clk);
        seed_valid = 1'b0;
        check(early == 0 && scan_en, {req, " fill starts after length bits (R2 R3 R9)"}, early, 0);
        collect(m, junk, 1'b1, req);
    endtask

    task automatic run_rand(input logic junk, input logic next_det, input string req);
        mode_det = 1'b0;
        check(!scan_en, {req, " idle gap (R7)"}, scan_en, 0);
        if (junk) begin
            seed_valid = 1'b1;
            seed_bit   = 1'b1;
        end
        @(negedge clk);
        check(scan_en, {req, " fill begins (R7)"}, scan_en, 1);
        collect(rmodel, junk, next_det, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!scan_en && !pattern_done && !scan_out, "R1 reset outputs", {scan_en, pattern_done}, 0);
        rst_n = 1'b1;

        // Table walk: lengths 8..32, stalls, serial traffic during fills (R2 R3 R4 R9)
        for (int v = 0; v < NVEC; v++) begin
            run_det(VEC[v][32], VEC[v][33], VEC[v][34], VEC[v][31:0], int'(VEC[v][47:40]),
                    $sformatf("R4 vec%0d", v));
        end

        // Zero seed leaves an all-zero register; free-running entry must preset it (R8)
        run_det(1'b0, 1'b0, 1'b0, 32'h0, 32, "R4 zero seed");
        rmodel = RINIT;
        run_rand(1'b0, 1'b0, "R8 preset");
        // Continuation and ignored serial input in free-running mode (R7)
        run_rand(1'b1, 1'b1, "R7 continue");

        // Deterministic again without reset: length still saturated
        run_det(1'b0, 1'b0, 1'b0, 32'h5555_AAAA, 32, "R3 held length");

        // Mid-run reset returns length to base (R1)
        seed_valid = 1'b1;
        seed_bit   = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        seed_valid = 1'b0;
        @(negedge clk);
        check(!scan_en && !pattern_done, "R1 reset mid-frame", scan_en, 0);
        rst_n = 1'b1;
        run_det(1'b0, 1'b0, 1'b0, 32'hFFFF_FF96, 8, "R1 base length after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule